// File: doc/BRIEF.md
# PLL Register Programming Sequencer

This block walks a frequency synthesizer through its power-up register programming. On a start pulse it presents configuration words one at a time to an external SPI master. It holds each word until the master reports that the word has been shifted out, then moves to the next word. Partway through it pauses for a calibration settling interval, which it measures in rising edges of a slow ADC clock tick. The integrating logic supplies the register images; this block changes only two control bits inside them: the counter-reset bit of R4 and the autocalibration bit of R0.

There are two programs, and the mode flag sampled with the start pulse selects one.

**Direct program.** R10, R4, R2, R1, R0, R4, settle, R0. All words come from the target images.

**High-comparison-frequency program.** The same first phase, but built from the halved images. After the calibration write it continues with R4, R2, R1 and R0 from the target images. A frequency change takes effect only when R0 is written, so every phase ends on an R0 write.

**FSM states and transitions.** Each send state hands off to the next one on an acknowledge while the word is valid.

- IDLE → R10 on start.
- R10 → R4_RST → R2_A → R1_A → R0_A → R4_RUN.
- R4_RUN → SETTLE on acknowledge.
- SETTLE → R0_CAL once 17 tick edges have been counted.
- R0_CAL → IDLE in direct mode, or R0_CAL → R4_TGT in high mode.
- R4_TGT → R2_TGT → R1_TGT → R0_TGT.
- R0_TGT → IDLE.

Top module: `pll_seq_top`

## Requirements
- R1: After reset and while idle, busy_o, word_vld_o and done_o are 0.
- R2: A start_i pulse while idle makes busy_o 1 in the following cycle, and the first word offered is the R10 image. The mode flag is captured with that pulse.
- R3: With mode_hi_i=1, the words in order are:
  - R10
  - half R4, half R2, half R1, half R0, half R4
  - (settle interval)
  - half R0
  - target R4, target R2, target R1, target R0

  That is 11 words in total.
- R4: With mode_hi_i=0, the words in order are R10, then target R4, R2, R1, R0, R4, then (settle interval), then target R0. That is 7 words in total.
- R5: In the R4 word that directly follows R10, bit 4 is forced to 1. In every later R4 word, bit 4 is forced to 0. All other bits pass through unchanged.
- R6: In the R0 word directly after the settle interval, bit 21 is forced to 1. In every other R0 word, bit 21 is forced to 0. All other bits pass through unchanged.
- R7: During the settle interval, word_vld_o is 0. The sequencer releases only after the 17th rising edge of the synchronized adc_tick_i counted in that interval. After 16 edges it is still waiting.
- R8: While word_vld_o is 1 and word_ack_i is 0, word_vld_o stays 1 and word_o stays unchanged. An acknowledge while no word is valid has no effect.
- R9: A start_i pulse while busy_o is 1 is ignored. The running program and its mode do not change.
- R10: done_o pulses for exactly one cycle, in the cycle after the final R0 acknowledge. busy_o is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| mode_hi_i | input | 1 | 1 selects the high-comparison-frequency program |
| r10_i | input | 32 | R10 image |
| half_r0_i | input | 32 | R0 image for the halved comparison frequency |
| half_r1_i | input | 32 | R1 image for the halved comparison frequency |
| half_r2_i | input | 32 | R2 image for the halved comparison frequency |
| half_r4_i | input | 32 | R4 image with the doubled R divider |
| tgt_r0_i | input | 32 | R0 image for the target |
| tgt_r1_i | input | 32 | R1 image for the target |
| tgt_r2_i | input | 32 | R2 image for the target |
| tgt_r4_i | input | 32 | R4 image for the target |
| adc_tick_i | input | 1 | Slow ADC clock, asynchronous to clk |
| word_ack_i | input | 1 | SPI master: the current word has been shifted out |
| word_o | output | 32 | Word to send |
| word_vld_o | output | 1 | word_o is valid |
| busy_o | output | 1 | A program is running |
| done_o | output | 1 | Single-cycle completion pulse |

## Verification
The assertions check the handshake hold, the done pulse and its coincidence with idle, the quiet output while idle, the start response, and the bounds and stepping of the tick counter. They check these on every cycle. Only the bench scenarios can show the full word order of each program and the two forced control bits in their exact positions. The same goes for the release after the 17th edge and not the 16th, and for the start pulse that is ignored mid-program.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_R10,
        S_R4_RST,
        S_R2_A,
        S_R1_A,
        S_R0_A,
        S_R4_RUN,
        S_SETTLE,
        S_R0_CAL,
        S_R4_TGT,
        S_R2_TGT,
        S_R1_TGT,
        S_R0_TGT
    } seq_state_e;
endpackage

// File: rtl/pll_seq_wait.sv
module pll_seq_wait #(
    parameter int SYNC_STAGES = 2,
    parameter int WAIT_EDGES  = 17,
    localparam int CNT_W      = $clog2(WAIT_EDGES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    output logic             settled_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   edge_w;
    logic [CNT_W-1:0]       cnt_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= tick_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_w = sync_q[SYNC_STAGES-1] & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       cnt_q <= '0;
        else if (!en_i)                                   cnt_q <= '0;
        else if (edge_w && cnt_q != CNT_W'(WAIT_EDGES))   cnt_q <= cnt_q + 1'b1;
    end

    assign settled_o = (cnt_q == CNT_W'(WAIT_EDGES));
    assign cnt_o     = cnt_q;
endmodule

// File: rtl/pll_seq_word.sv
module pll_seq_word
    import pll_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int RST_BIT = 4,
    parameter int CAL_BIT = 21
) (
    input  seq_state_e        state_i,
    input  logic              hi_i,
    input  logic [DATA_W-1:0] r10_i,
    input  logic [DATA_W-1:0] half_r0_i,
    input  logic [DATA_W-1:0] half_r1_i,
    input  logic [DATA_W-1:0] half_r2_i,
    input  logic [DATA_W-1:0] half_r4_i,
    input  logic [DATA_W-1:0] tgt_r0_i,
    input  logic [DATA_W-1:0] tgt_r1_i,
    input  logic [DATA_W-1:0] tgt_r2_i,
    input  logic [DATA_W-1:0] tgt_r4_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] ph_r0, ph_r1, ph_r2, ph_r4;

    assign ph_r0 = hi_i ? half_r0_i : tgt_r0_i;
    assign ph_r1 = hi_i ? half_r1_i : tgt_r1_i;
    assign ph_r2 = hi_i ? half_r2_i : tgt_r2_i;
    assign ph_r4 = hi_i ? half_r4_i : tgt_r4_i;

    always_comb begin
        word_o = '0;
        unique case (state_i)
            S_R10:    word_o = r10_i;
            S_R4_RST: begin word_o = ph_r4; word_o[RST_BIT] = 1'b1; end
            S_R2_A:   word_o = ph_r2;
            S_R1_A:   word_o = ph_r1;
            S_R0_A:   begin word_o = ph_r0; word_o[CAL_BIT] = 1'b0; end
            S_R4_RUN: begin word_o = ph_r4; word_o[RST_BIT] = 1'b0; end
            S_R0_CAL: begin word_o = ph_r0; word_o[CAL_BIT] = 1'b1; end
            S_R4_TGT: begin word_o = tgt_r4_i; word_o[RST_BIT] = 1'b0; end
            S_R2_TGT: word_o = tgt_r2_i;
            S_R1_TGT: word_o = tgt_r1_i;
            S_R0_TGT: begin word_o = tgt_r0_i; word_o[CAL_BIT] = 1'b0; end
            default:  word_o = '0;
        endcase
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_hi_i,
    input  logic       ack_i,
    input  logic       settled_i,
    output seq_state_e state_o,
    output logic       hi_o,
    output logic       vld_o,
    output logic       busy_o,
    output logic       settle_en_o,
    output logic       done_o
);
    seq_state_e state_q, state_d;
    logic       hi_q, done_q, last_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            hi_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) hi_q <= mode_hi_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i)   state_d = S_R10;
            S_R10:    if (ack_i)     state_d = S_R4_RST;
            S_R4_RST: if (ack_i)     state_d = S_R2_A;
            S_R2_A:   if (ack_i)     state_d = S_R1_A;
            S_R1_A:   if (ack_i)     state_d = S_R0_A;
            S_R0_A:   if (ack_i)     state_d = S_R4_RUN;
            S_R4_RUN: if (ack_i)     state_d = S_SETTLE;
            S_SETTLE: if (settled_i) state_d = S_R0_CAL;
            S_R0_CAL: if (ack_i)     state_d = hi_q ? S_R4_TGT : S_IDLE;
            S_R4_TGT: if (ack_i)     state_d = S_R2_TGT;
            S_R2_TGT: if (ack_i)     state_d = S_R1_TGT;
            S_R1_TGT: if (ack_i)     state_d = S_R0_TGT;
            S_R0_TGT: if (ack_i)     state_d = S_IDLE;
            default:                 state_d = S_IDLE;
        endcase
    end

    always_comb begin
        busy_o      = (state_q != S_IDLE);
        settle_en_o = (state_q == S_SETTLE);
        vld_o       = busy_o && !settle_en_o;
        last_ack    = ack_i && ((state_q == S_R0_CAL && !hi_q) || state_q == S_R0_TGT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_ack;
    end

    assign state_o = state_q;
    assign hi_o    = hi_q;
    assign done_o  = done_q;
endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int WAIT_EDGES  = 17,
    parameter int SYNC_STAGES = 2,
    parameter int RST_BIT     = 4,
    parameter int CAL_BIT     = 21,
    localparam int CNT_W      = $clog2(WAIT_EDGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_hi_i,
    input  logic [DATA_W-1:0] r10_i,
    input  logic [DATA_W-1:0] half_r0_i,
    input  logic [DATA_W-1:0] half_r1_i,
    input  logic [DATA_W-1:0] half_r2_i,
    input  logic [DATA_W-1:0] half_r4_i,
    input  logic [DATA_W-1:0] tgt_r0_i,
    input  logic [DATA_W-1:0] tgt_r1_i,
    input  logic [DATA_W-1:0] tgt_r2_i,
    input  logic [DATA_W-1:0] tgt_r4_i,
    input  logic              adc_tick_i,
    input  logic              word_ack_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_e       state_w;
    logic             hi_w, settled_w, settle_en_w, vld_w;
    logic [CNT_W-1:0] wait_cnt;

    pll_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_hi_i   (mode_hi_i),
        .ack_i       (word_ack_i && vld_w),
        .settled_i   (settled_w),
        .state_o     (state_w),
        .hi_o        (hi_w),
        .vld_o       (vld_w),
        .busy_o      (busy_o),
        .settle_en_o (settle_en_w),
        .done_o      (done_o)
    );

    pll_seq_wait #(.SYNC_STAGES(SYNC_STAGES), .WAIT_EDGES(WAIT_EDGES)) u_wait (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (adc_tick_i),
        .en_i      (settle_en_w),
        .settled_o (settled_w),
        .cnt_o     (wait_cnt)
    );

    pll_seq_word #(.DATA_W(DATA_W), .RST_BIT(RST_BIT), .CAL_BIT(CAL_BIT)) u_word (
        .state_i   (state_w),
        .hi_i      (hi_w),
        .r10_i     (r10_i),
        .half_r0_i (half_r0_i),
        .half_r1_i (half_r1_i),
        .half_r2_i (half_r2_i),
        .half_r4_i (half_r4_i),
        .tgt_r0_i  (tgt_r0_i),
        .tgt_r1_i  (tgt_r1_i),
        .tgt_r2_i  (tgt_r2_i),
        .tgt_r4_i  (tgt_r4_i),
        .word_o    (word_o)
    );

    assign word_vld_o = vld_w;
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
    parameter int DATA_W     = 32,
    parameter int WAIT_EDGES = 17,
    parameter int CNT_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              word_ack_i,
    input logic [DATA_W-1:0] word_o,
    input logic              word_vld_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CNT_W-1:0]  wait_cnt
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !word_vld_o);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= CNT_W'(WAIT_EDGES));

    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_cnt != $past(wait_cnt)) |-> (wait_cnt == '0 || wait_cnt == $past(wait_cnt) + 1'b1));

    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_o && !word_ack_i) |=> (word_vld_o && $stable(word_o)));

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind pll_seq_top pll_seq_chk #(.DATA_W(DATA_W), .WAIT_EDGES(WAIT_EDGES), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .word_ack_i (word_ack_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wait_cnt   (wait_cnt)
);

// File: tb/tb_pll_seq_top.sv
module tb_pll_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, mode_hi_i = 1'b0, adc_tick_i = 1'b0, word_ack_i = 1'b0;
    logic [31:0] r10, h0, h1, h2, h4, t0, t1, t2, t4;
    logic [31:0] word_o;
    logic        word_vld_o, busy_o, done_o;
    int          total = 0, bad = 0;

    localparam logic [32:0] VEC [4] = '{
        {1'b1, 32'hA5C3_0F11},
        {1'b0, 32'h1234_5678},
        {1'b1, 32'hFFFF_FFFF},
        {1'b0, 32'h0000_0000}
    };

    always #10 clk = ~clk;

    pll_seq_top dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_hi_i(mode_hi_i),
        .r10_i(r10), .half_r0_i(h0), .half_r1_i(h1), .half_r2_i(h2), .half_r4_i(h4),
        .tgt_r0_i(t0), .tgt_r1_i(t1), .tgt_r2_i(t2), .tgt_r4_i(t4),
        .adc_tick_i(adc_tick_i), .word_ack_i(word_ack_i),
        .word_o(word_o), .word_vld_o(word_vld_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] setb(input logic [31:0] w, input int b, input logic v);
        logic [31:0] r = w;
        r[b] = v;
        return r;
    endfunction

    function automatic logic [31:0] exp_word(input logic hi, input int idx);
        if (hi) begin
            case (idx)
                0: return r10;
                1: return setb(h4, 4, 1'b1);
                2: return h2;
                3: return h1;
                4: return setb(h0, 21, 1'b0);
                5: return setb(h4, 4, 1'b0);
                6: return setb(h0, 21, 1'b1);
                7: return setb(t4, 4, 1'b0);
                8: return t2;
                9: return t1;
                default: return setb(t0, 21, 1'b0);
            endcase
        end else begin
            case (idx)
                0: return r10;
                1: return setb(t4, 4, 1'b1);
                2: return t2;
                3: return t1;
                4: return setb(t0, 21, 1'b0);
                5: return setb(t4, 4, 1'b0);
                default: return setb(t0, 21, 1'b1);
            endcase
        end
    endfunction

    task automatic load(input logic [31:0] s);
        r10 = s;
        h0 = s ^ 32'h0101_0101; h1 = s ^ 32'h0202_0202;
        h2 = s ^ 32'h0303_0303; h4 = s ^ 32'h0404_0404;
        t0 = s ^ 32'h0505_0505; t1 = s ^ 32'h0606_0606;
        t2 = s ^ 32'h0707_0707; t4 = s ^ 32'h0808_0808;
    endtask

    task automatic pulse_start(input logic m);
        @(negedge clk); start_i = 1'b1; mode_hi_i = m;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); word_ack_i = 1'b1;
        @(negedge clk); word_ack_i = 1'b0;
    endtask

    task automatic tick();
        adc_tick_i = 1'b1; repeat (3) @(negedge clk);
        adc_tick_i = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic wait_vld(output int n);
        n = 0;
        while (!word_vld_o && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic run_prog(input logic hi, input bit poke_start);
        int nw = hi ? 11 : 7;
        int n;
        logic [31:0] held;
        for (int idx = 0; idx < nw; idx++) begin
            if (idx == 6) begin
                chk(word_vld_o == 1'b0, "R7 silent in settle", {31'b0, word_vld_o}, 32'h0);
                for (int k = 0; k < 16; k++) tick();
                repeat (6) @(negedge clk);
                chk(word_vld_o == 1'b0, "R7 no release after 16 edges", {31'b0, word_vld_o}, 32'h0);
                tick();
            end
            wait_vld(n);
            if (idx == 6)
                chk(n <= 10, "R7 release after 17th edge", n, 10);
            chk(word_vld_o && word_o == exp_word(hi, idx),
                hi ? "R3 R5 R6 high word" : "R4 R5 R6 direct word", word_o, exp_word(hi, idx));
            held = word_o;
            repeat (1 + (idx % 3) * 4) @(negedge clk);
            chk(word_vld_o && word_o == held, "R8 word held until ack", word_o, held);
            ack();
            if (poke_start && idx == 2) begin
                @(negedge clk); start_i = 1'b1; mode_hi_i = ~hi;
                @(negedge clk); start_i = 1'b0;
            end
        end
        chk(done_o == 1'b1 && busy_o == 1'b0, "R10 done with busy low",
            {30'b0, done_o, busy_o}, 32'h2);
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single cycle", {31'b0, done_o}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        load(32'h0);
        repeat (3) @(negedge clk);
        chk(!busy_o && !word_vld_o && !done_o, "R1 reset state",
            {29'b0, busy_o, word_vld_o, done_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !word_vld_o && !done_o, "R1 idle after reset",
            {29'b0, busy_o, word_vld_o, done_o}, 32'h0);

        for (int v = 0; v < 4; v++) begin
            load(VEC[v][31:0]);
            pulse_start(VEC[v][32]);
            chk(busy_o == 1'b1, "R2 busy after start", {31'b0, busy_o}, 32'h1);
            chk(word_o == r10, "R2 first word R10", word_o, r10);
            run_prog(VEC[v][32], v < 2);
            repeat (3) @(negedge clk);
        end

        // R8: an acknowledge while idle has no effect
        @(negedge clk); word_ack_i = 1'b1;
        @(negedge clk); word_ack_i = 1'b0;
        @(negedge clk);
        chk(!busy_o && !word_vld_o && !done_o, "R8 idle ack ignored",
            {29'b0, busy_o, word_vld_o, done_o}, 32'h0);

        // R9: start repeated while busy keeps the first word offered
        load(32'h3C3C_C3C3);
        pulse_start(1'b0);
        pulse_start(1'b1);
        chk(word_vld_o && word_o == r10, "R9 start while busy ignored", word_o, r10);
        ack();
        chk(word_o == exp_word(1'b0, 1), "R9 mode unchanged", word_o, exp_word(1'b0, 1));

        // R1: reset during a program returns to idle
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!busy_o && !word_vld_o, "R1 reset mid program", {30'b0, busy_o, word_vld_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_start(1'b1);
        chk(word_vld_o && word_o == r10, "R2 restart after reset", word_o, r10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule